// File: doc/BRIEF.md
# Per-Pixel Hit Timestamp Buffer

This block holds the digital hit record of one detector pixel. A discriminator output arrives as a synchronous hit input, and every pixel shares a free-running 14-bit time counter bus that advances at roughly 3 MHz. When the hit input rises, the block stores the current bus value into the next free slot of a small local memory and moves its write pointer on. A second hit that arrives before readout has finished goes into the following slot. Hits that arrive while every slot is full are dropped, and a sticky overflow flag records the loss.

During readout the block presents its oldest stored stamp on the data output. Each read acknowledge removes one entry. An empty indication is raised whenever nothing is stored, so a readout multiplexer can step past the pixel at once. A clear input ends a bunch train: it empties the memory, rewinds both pointers and drops the overflow flag. For memory testing, an external write port loads any value into any chosen slot without going through the hit path. The read output always shows the slot at the read pointer, so the loaded value can be read back.

Top module: `pixel_stamp_buffer`

## Requirements
- R1: After reset, rdEmpty is 1, overflow is 0, and rdData is 0. Both pointers start at slot 0.
- R2: A clock edge at which hitIn is 1 and was 0 at the previous edge stores the stampBus value present at that edge. From the next cycle, rdEmpty is 0 and rdData shows that value when the memory was empty before.
- R3: While hitIn is held high for several cycles, only one stamp is stored: the one taken at the rising edge.
- R4: Stamps are stored in slots 0, 1, ... in the order they arrive, wrapping after slot DEPTH-1. Readout returns them in arrival order.
- R5: When rdAck is 1 at a clock edge and at least one entry is stored, exactly one entry is removed. rdEmpty becomes 1 once the last entry has been removed.
- R6: When rdAck arrives while the memory is empty, it is ignored. Occupancy stays zero, and the read pointer does not move.
- R7: When a hit arrives while all DEPTH slots (2 by default) are full, it is dropped. It does not change the stored stamps, and it sets overflow. Overflow stays set until clearIn.
- R8: clearIn at a clock edge empties the memory, sets all slots to 0, clears overflow and returns both pointers to slot 0. It takes priority over a hit or an acknowledge at the same edge.
- R9: testWrEn at a clock edge writes testWrData into slot testWrAddr and leaves occupancy and pointers unchanged. rdData always shows the slot at the read pointer, even when rdEmpty is 1.
- R10: When a test write and a hit capture target the same slot at the same edge, the slot takes testWrData. The capture still advances the write pointer and the occupancy.
- R11: When a hit and an acknowledge happen at the same edge while one entry is stored, occupancy stays 1 and rdData shows the new stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitIn | input | 1 | Synchronous discriminator output; its rising edge is a hit |
| stampBus | input | STAMP_W (14) | Shared time counter value |
| rdAck | input | 1 | Readout acknowledge; removes the oldest entry |
| clearIn | input | 1 | End of readout; empties the pixel and clears overflow |
| testWrEn | input | 1 | Test write strobe |
| testWrAddr | input | SLOT_W (1) | Slot written by a test write |
| testWrData | input | STAMP_W (14) | Value written by a test write |
| rdData | output | STAMP_W (14) | Contents of the slot at the read pointer |
| rdEmpty | output | 1 | High when no entry is stored |
| overflow | output | 1 | Sticky flag: a hit was dropped because the memory was full |

## Verification
The embedded properties check these rules on every cycle: occupancy never exceeds the depth, a held hit never adds an entry, a hit into a full memory keeps it full and raises overflow, overflow persists until a clear, a clear always leaves the pixel empty, and both the capture and the test-write paths land the expected value in the addressed slot. The bench scenarios alone show that readout order matches arrival order across pointer wraps. They also show that an acknowledge on an empty pixel does not corrupt later captures, how a clear, a test write or an acknowledge interacts with a hit at the same edge, and that a test-loaded value is visible on rdData while the pixel reports empty.

// File: rtl/pixstamp_pkg.sv
package pixstamp_pkg;

  // Strobes issued by the control to the storage datapath each cycle.
  typedef struct packed {
    logic capture;   // store the bus value into the write slot
    logic clear;     // wipe all slots
  } stampStrobe_t;

endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import pixstamp_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitIn,
  input  logic              rdAck,
  input  logic              clearIn,
  output stampStrobe_t      strobe,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              rdEmpty,
  output logic              overflow
);

  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

  logic              hitPrev;
  logic [SLOT_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              overflowQ;

  logic hitRise, isFull, isEmpty;
  logic doCapture, doPop, dropHit;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    hitRise   = hitIn & ~hitPrev;
    isFull    = (count == FULL_CNT);
    isEmpty   = (count == '0);
    doCapture = hitRise & ~isFull & ~clearIn;
    dropHit   = hitRise & isFull & ~clearIn;
    doPop     = rdAck & ~isEmpty & ~clearIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrev   <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      overflowQ <= 1'b0;
    end else begin
      hitPrev <= hitIn;
      if (clearIn) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        count     <= '0;
        overflowQ <= 1'b0;
      end else begin
        if (doCapture) wrPtr <= bump(wrPtr);
        if (doPop)     rdPtr <= bump(rdPtr);
        case ({doCapture, doPop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
        if (dropHit) overflowQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.capture = doCapture;
    strobe.clear   = clearIn;
    wrSlot         = wrPtr;
    rdSlot         = rdPtr;
    rdEmpty        = isEmpty;
    overflow       = overflowQ;
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R3
  held_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && $past(hitIn)) |=> (count <= $past(count)));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && hitIn && !hitPrev && !clearIn && !rdAck) |=> (isFull && overflowQ));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowQ && !clearIn) |=> overflowQ);

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (rdEmpty && !overflow && wrPtr == '0 && rdPtr == '0));

  // R6
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && rdAck && !(hitIn && !hitPrev)) |=> (isEmpty && $stable(rdPtr)));

endmodule

// File: rtl/stamp_store.sv
module stamp_store
  import pixstamp_pkg::*;
#(
  parameter int STAMP_W = 14,
  parameter int DEPTH = 2,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stampStrobe_t       strobe,
  input  logic [SLOT_W-1:0]  wrSlot,
  input  logic [SLOT_W-1:0]  rdSlot,
  input  logic [STAMP_W-1:0] stampBus,
  input  logic               testWrEn,
  input  logic [SLOT_W-1:0]  testWrAddr,
  input  logic [STAMP_W-1:0] testWrData,
  output logic [STAMP_W-1:0] rdData
);

  logic [STAMP_W-1:0] slotMem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic testSel, capSel;
    always_comb begin
      testSel = testWrEn && (testWrAddr == SLOT_W'(i));
      capSel  = strobe.capture && (wrSlot == SLOT_W'(i));
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            slotMem[i] <= '0;
      else if (testSel)     slotMem[i] <= testWrData;
      else if (strobe.clear) slotMem[i] <= '0;
      else if (capSel)      slotMem[i] <= stampBus;
    end
  end

  assign rdData = slotMem[rdSlot];

  // R9
  test_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testWrEn && int'(testWrAddr) < DEPTH) |=>
      (slotMem[$past(testWrAddr)] == $past(testWrData)));

  // R2
  capture_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !(testWrEn && testWrAddr == wrSlot)) |=>
      (slotMem[$past(wrSlot)] == $past(stampBus)));

endmodule

// File: rtl/pixel_stamp_buffer.sv
module pixel_stamp_buffer
  import pixstamp_pkg::*;
#(
  parameter int STAMP_W = 14,
  parameter int DEPTH = 2,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hitIn,
  input  logic [STAMP_W-1:0] stampBus,
  input  logic               rdAck,
  input  logic               clearIn,
  input  logic               testWrEn,
  input  logic [SLOT_W-1:0]  testWrAddr,
  input  logic [STAMP_W-1:0] testWrData,
  output logic [STAMP_W-1:0] rdData,
  output logic               rdEmpty,
  output logic               overflow
);

  stampStrobe_t      strobe;
  logic [SLOT_W-1:0] wrSlot, rdSlot;

  stamp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .rdAck(rdAck), .clearIn(clearIn),
    .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .rdEmpty(rdEmpty), .overflow(overflow)
  );

  stamp_store #(.STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .stampBus(stampBus), .testWrEn(testWrEn), .testWrAddr(testWrAddr),
    .testWrData(testWrData), .rdData(rdData)
  );

endmodule

// File: tb/pixel_stamp_buffer_bench.sv
module pixel_stamp_buffer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hitIn = 1'b0;
  logic [13:0] stampBus = '0;
  logic        rdAck = 1'b0;
  logic        clearIn = 1'b0;
  logic        testWrEn = 1'b0;
  logic [0:0]  testWrAddr = '0;
  logic [13:0] testWrData = '0;
  logic [13:0] rdData;
  logic        rdEmpty;
  logic        overflow;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  pixel_stamp_buffer u_pixel_stamp_buffer (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .stampBus(stampBus), .rdAck(rdAck),
    .clearIn(clearIn), .testWrEn(testWrEn), .testWrAddr(testWrAddr),
    .testWrData(testWrData), .rdData(rdData), .rdEmpty(rdEmpty), .overflow(overflow)
  );

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulseHit(input logic [13:0] s);
    hitIn = 1'b1; stampBus = s;
    @(negedge clk);
    hitIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    rdAck = 1'b1;
    @(negedge clk);
    rdAck = 1'b0;
  endtask

  task automatic doClear();
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
  endtask

  function automatic logic [13:0] stampOf(input int n, input int k);
    return 14'((n * 1000 + k * 4099 + 7) & 16'h3fff);
  endfunction

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 empty", rdEmpty, 1);
    chk("R1 overflow", overflow, 0);
    chk("R1 data", rdData, 0);

    // R2 R4 R5 R6 R7: sweep 0..4 hits per train
    for (int n = 0; n <= 4; n++) begin
      int stored;
      doClear();
      for (int k = 0; k < n; k++) pulseHit(stampOf(n, k));
      stored = (n < 2) ? n : 2;
      chk("R7 overflow", overflow, (n > 2) ? 1 : 0);
      for (int k = 0; k < stored; k++) begin
        chk("R5 not empty", rdEmpty, 0);
        chk("R4 order", rdData, stampOf(n, k));
        ack();
      end
      chk("R5 empty after last", rdEmpty, 1);
      ack();
      chk("R6 ack on empty", rdEmpty, 1);
      pulseHit(14'h3fff - 14'(n));
      chk("R6 capture after empty ack", rdData, 14'h3fff - n);
      chk("R2 not empty", rdEmpty, 0);
      ack();
      chk("R7 overflow held", overflow, (n > 2) ? 1 : 0);
    end
    doClear();
    chk("R8 overflow cleared", overflow, 0);

    // R3: held hit
    doClear();
    hitIn = 1'b1;
    for (int c = 0; c < 5; c++) begin
      stampBus = 14'(100 + c);
      @(negedge clk);
    end
    hitIn = 1'b0;
    @(negedge clk);
    chk("R3 first stamp", rdData, 100);
    ack();
    chk("R3 single entry", rdEmpty, 1);

    // R8: clear has priority over hit
    doClear();
    pulseHit(14'd55);
    clearIn = 1'b1; hitIn = 1'b1; stampBus = 14'd77;
    @(negedge clk);
    clearIn = 1'b0; hitIn = 1'b0;
    @(negedge clk);
    chk("R8 empty", rdEmpty, 1);
    chk("R8 slots zeroed", rdData, 0);

    // R9: test write readback on both slots
    testWrEn = 1'b1; testWrAddr = 1'b0; testWrData = 14'h1234;
    @(negedge clk);
    testWrEn = 1'b0;
    chk("R9 slot0 readback", rdData, 14'h1234);
    chk("R9 occupancy unchanged", rdEmpty, 1);
    pulseHit(14'd9);
    ack();
    testWrEn = 1'b1; testWrAddr = 1'b1; testWrData = 14'h2abc;
    @(negedge clk);
    testWrEn = 1'b0;
    chk("R9 slot1 readback", rdData, 14'h2abc);
    chk("R9 still empty", rdEmpty, 1);

    // R10: test write beats capture in same slot
    doClear();
    hitIn = 1'b1; stampBus = 14'd500;
    testWrEn = 1'b1; testWrAddr = 1'b0; testWrData = 14'd321;
    @(negedge clk);
    hitIn = 1'b0; testWrEn = 1'b0;
    @(negedge clk);
    chk("R10 test data wins", rdData, 321);
    chk("R10 capture counted", rdEmpty, 0);
    pulseHit(14'd600);
    chk("R10 pointer advanced", overflow, 0);
    ack();
    chk("R10 second slot", rdData, 600);

    // R11: hit and ack in same cycle
    doClear();
    pulseHit(14'd11);
    hitIn = 1'b1; stampBus = 14'd22; rdAck = 1'b1;
    @(negedge clk);
    hitIn = 1'b0; rdAck = 1'b0;
    @(negedge clk);
    chk("R11 occupied", rdEmpty, 0);
    chk("R11 new stamp", rdData, 22);
    ack();
    chk("R11 empty after one", rdEmpty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule